// File: doc/BRIEF.md
# Page Write Buffer and Cycle Sequencer

This block sits between the serial protocol controller of a byte-wide non-volatile memory and its storage array. While a write command arrives, the controller hands it a row (page) address, a starting column and a strobe for each data byte. Each byte is held in a 128-entry page latch. A per-column valid map records which columns the command touched. The column pointer covers only the low seven address bits and wraps inside the row. A byte sent to a column that already holds one replaces it.

When the controller signals a stop that falls in the slot right after a data acknowledge, the block starts one timed internal write cycle. It copies only the marked columns into the array, one per clock, lowest column first. It then keeps `busy` high until a fixed number of system clocks has passed, and clears the valid map when `busy` drops. While `busy` is high every input is ignored. An abort, or a new start condition seen before such a stop, throws the latched bytes away and leaves the array untouched. A byte received while the write-inhibit input is high is not latched, but the column pointer still moves past it.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy` and `mem_we` are low.
- R2: A byte accepted at column c of a command whose row is r is written to array address {r, c} (row in bits 16:7, column in bits 6:0) with exactly the byte value received, once the command is committed by `stop_ok`.
- R3: The column advances by one after each strobed byte and wraps from 127 to 0 within the same row. When two bytes of one command land on the same column, only the later one is written, and that column is written only once.
- R4: During a write cycle, exactly the columns that received a latched byte are written. No other column of the row gets a write pulse.
- R5: Array writes come on consecutive clocks in strictly increasing column order. The first write falls in the first cycle in which `busy` is high.
- R6: `busy` rises in the clock after an accepted `stop_ok` and stays high for exactly WRITE_CYCLES clock cycles.
- R7: An `abort`, or a `bus_start` that arrives before `stop_ok`, discards the latched bytes. No write pulse follows and `busy` stays low.
- R8: A byte strobed while `wr_inhibit` is high is not latched, but the column still advances past it. A command whose bytes were all inhibited starts no write cycle on `stop_ok`.
- R9: While `busy` is high, byte strobes, address loads, starts, aborts and `stop_ok` have no effect. After `busy` falls, the valid map is empty, so a lone `stop_ok` starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Pulse: start or repeated start condition seen on the bus |
| addr_load | input | 1 | Pulse: capture `row_in` and `col_in` as the command's address |
| row_in | input | 10 | Row (page) address, array address bits 16:7 |
| col_in | input | 7 | Starting column, array address bits 6:0 |
| byte_stb | input | 1 | Pulse: a data byte of the write command is present |
| byte_data | input | 8 | Data byte qualified by `byte_stb` |
| wr_inhibit | input | 1 | Write-protect level, sampled with each byte strobe |
| stop_ok | input | 1 | Pulse: stop received in the slot right after a data acknowledge |
| abort | input | 1 | Pulse: command ended any other way |
| busy | output | 1 | Internal write cycle in progress; inputs are ignored |
| mem_we | output | 1 | Array write enable, one byte per clock |
| mem_addr | output | 17 | Array write address {row, column} |
| mem_wdata | output | 8 | Array write data |

## Verification
The hardest case to reach from the ports is a command whose column pointer both wraps past 127 and lands twice on the same columns, combined with inhibited bytes in between. In that case the map of written columns no longer matches the byte count. The stimulus reaches it with a 130-byte command from column 0, with a command that starts at column 120, and with a command where every other byte is inhibited. For each of these, the bench rebuilds the expected page image and valid map from the requirements. It also strobes bytes, a new address and a stop in the middle of a running cycle, then sends a lone stop after `busy` falls, to show that nothing got latched while the block was blind.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_CYCLE = 1'b1
  } seq_state_e;
endpackage

// File: rtl/pwb_colptr.sv
module pwb_colptr #(
  parameter int ROW_W = 10,
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] row_in,
  input  logic [COL_W-1:0] col_in,
  input  logic             adv,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;

  always_comb begin
    row_d = row;
    col_d = col;
    if (load) begin
      row_d = row_in;
      col_d = col_in;
    end else if (adv) begin
      col_d = col + COL_W'(1);   // wraps inside the row
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (load || adv) begin
      row <= row_d;
      col <= col_d;
    end
  end
endmodule

// File: rtl/pwb_latch.sv
module pwb_latch #(
  parameter int COL_W  = 7,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data,
  output logic [DEPTH-1:0]  valid
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  valid_d;

  // Data cells carry no reset; the valid map qualifies them.
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_col] <= wr_data;
  end

  assign rd_data = store[rd_col];

  always_comb begin
    valid_d = valid;
    if (clr) valid_d = '0;
    else if (wr_en) valid_d[wr_col] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= '0;
    else if (clr || wr_en) valid <= valid_d;
  end
endmodule

// File: rtl/pwb_seq.sv
module pwb_seq
  import pwb_pkg::*;
#(
  parameter int COL_W        = 7,
  parameter int WRITE_CYCLES = 100000,
  localparam int DEPTH = 1 << COL_W,
  localparam int TW    = $clog2(WRITE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [DEPTH-1:0] valid_in,
  output logic             busy,
  output logic             drain_we,
  output logic [COL_W-1:0] drain_col,
  output logic             done
);
  seq_state_e       state, state_d;
  logic [TW-1:0]    timer, timer_d;
  logic [DEPTH-1:0] pend, pend_d;
  logic             found;
  logic [COL_W-1:0] low_col;

  // lowest pending column
  always_comb begin
    low_col = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (pend[i]) low_col = COL_W'(i);
    end
  end
  assign found = |pend;

  always_comb begin
    state_d = state;
    timer_d = timer;
    pend_d  = pend;
    unique case (state)
      SEQ_IDLE: begin
        if (commit) begin
          state_d = SEQ_CYCLE;
          timer_d = TW'(WRITE_CYCLES - 1);
          pend_d  = valid_in;
        end
      end
      SEQ_CYCLE: begin
        if (found) pend_d[low_col] = 1'b0;
        if (timer == '0) state_d = SEQ_IDLE;
        else             timer_d = timer - TW'(1);
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      timer <= '0;
      pend  <= '0;
    end else begin
      state <= state_d;
      timer <= timer_d;
      pend  <= pend_d;
    end
  end

  assign busy      = (state == SEQ_CYCLE);
  assign drain_we  = busy && found;
  assign drain_col = low_col;
  assign done      = busy && (timer == '0);
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int ADDR_W       = 17,
  parameter int COL_W        = 7,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 100000,
  localparam int ROW_W = ADDR_W - COL_W,
  localparam int DEPTH = 1 << COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              addr_load,
  input  logic [ROW_W-1:0]  row_in,
  input  logic [COL_W-1:0]  col_in,
  input  logic              byte_stb,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              wr_inhibit,
  input  logic              stop_ok,
  input  logic              abort,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic             accept, clr_req, byte_take, latch_wr, commit, done;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col, drain_col;
  logic [DEPTH-1:0] valid;

  assign accept    = !busy;
  assign clr_req   = accept && (abort || bus_start);
  assign byte_take = accept && byte_stb && !clr_req;
  assign latch_wr  = byte_take && !wr_inhibit;
  assign commit    = accept && stop_ok && !clr_req && (|valid);

  pwb_colptr #(.ROW_W(ROW_W), .COL_W(COL_W)) u_colptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept && addr_load),
    .row_in (row_in),
    .col_in (col_in),
    .adv    (byte_take),
    .row    (row),
    .col    (col)
  );

  pwb_latch #(.COL_W(COL_W), .DATA_W(DATA_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (latch_wr),
    .wr_col  (col),
    .wr_data (byte_data),
    .clr     (clr_req || done),
    .rd_col  (drain_col),
    .rd_data (mem_wdata),
    .valid   (valid)
  );

  pwb_seq #(.COL_W(COL_W), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .valid_in  (valid),
    .busy      (busy),
    .drain_we  (mem_we),
    .drain_col (drain_col),
    .done      (done)
  );

  assign mem_addr = {row, drain_col};
endmodule

// File: rtl/page_write_seq_chk.sv
module page_write_seq_chk #(
  parameter int ADDR_W       = 17,
  parameter int COL_W        = 7,
  parameter int WRITE_CYCLES = 100000,
  localparam int CW = $clog2(WRITE_CYCLES + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              stop_ok
);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + CW'(1);
    else           run_cnt <= '0;
  end

  a_r5_we_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r5_first_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_we);

  a_r5_col_rising: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[COL_W-1:0] > $past(mem_addr[COL_W-1:0])));

  a_r2_row_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:COL_W]));

  a_r6_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ok));

  a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == CW'(WRITE_CYCLES)));

  a_r6_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < CW'(WRITE_CYCLES)));
endmodule

bind page_write_seq page_write_seq_chk #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we),
  .mem_addr(mem_addr), .stop_ok(stop_ok)
);

// File: tb/page_write_seq_bench.sv
`timescale 1ns/1ps
module page_write_seq_bench;
  localparam int W = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_start = 1'b0, addr_load = 1'b0, byte_stb = 1'b0;
  logic [9:0]  row_in = '0;
  logic [6:0]  col_in = '0;
  logic [7:0]  byte_data = '0;
  logic        wr_inhibit = 1'b0, stop_ok = 1'b0, abort = 1'b0;
  logic        busy, mem_we;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  page_write_seq #(.WRITE_CYCLES(W)) u_page_write_seq (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .addr_load(addr_load),
    .row_in(row_in), .col_in(col_in), .byte_stb(byte_stb), .byte_data(byte_data),
    .wr_inhibit(wr_inhibit), .stop_ok(stop_ok), .abort(abort),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // row, col, count, seed, end kind (0 stop, 1 abort, 2 new start)
  localparam logic [34:0] VEC [6] = '{
    {10'd3,   7'd0,   8'd1,   8'hA5, 2'd0},
    {10'h3FF, 7'd10,  8'd20,  8'h3C, 2'd0},
    {10'h155, 7'd120, 8'd12,  8'h11, 2'd0},
    {10'd7,   7'd0,   8'd130, 8'h80, 2'd0},
    {10'd9,   7'd5,   8'd4,   8'h22, 2'd1},
    {10'd9,   7'd5,   8'd4,   8'h22, 2'd2}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [9:0] row, input logic [6:0] col,
                         input int n, input logic [7:0] seed, input int kind,
                         input int wc_period, input bit inject, input string req);
    logic [127:0] ev;
    logic [7:0]   ed [128];
    logic [6:0]   m;
    logic [16:0]  wa [130];
    logic [7:0]   wd [130];
    int           wb [130];
    int           nw, bc, pop;
    bit           commit_exp;
    ev = '0;
    for (int i = 0; i < 128; i++) ed[i] = '0;
    @(posedge clk); #1 bus_start = 1'b1;
    @(posedge clk); #1 bus_start = 1'b0; addr_load = 1'b1; row_in = row; col_in = col;
    @(posedge clk); #1 addr_load = 1'b0;
    m = col;
    for (int i = 0; i < n; i++) begin
      byte_stb   = 1'b1;
      byte_data  = seed ^ 8'(i * 7);
      wr_inhibit = (wc_period != 0) && (i % wc_period == 0);
      if (!wr_inhibit) begin
        ev[m] = 1'b1;
        ed[m] = byte_data;
      end
      m = m + 7'd1;
      @(posedge clk); #1;
    end
    byte_stb = 1'b0; wr_inhibit = 1'b0;
    if (kind == 0) stop_ok = 1'b1;
    else if (kind == 1) abort = 1'b1;
    else bus_start = 1'b1;
    @(posedge clk); #1 stop_ok = 1'b0; abort = 1'b0; bus_start = 1'b0;
    nw = 0; bc = 0;
    for (int c = 0; c < W + 20; c++) begin
      @(negedge clk);
      if (busy) bc++;
      if (mem_we && nw < 130) begin
        wa[nw] = mem_addr; wd[nw] = mem_wdata; wb[nw] = bc; nw++;
      end
      if (inject && c == 3) begin
        byte_stb = 1'b1; byte_data = 8'hEE; stop_ok = 1'b1;
        addr_load = 1'b1; row_in = ~row; abort = 1'b1;
      end
      if (inject && c == 4) begin
        byte_stb = 1'b0; stop_ok = 1'b0; addr_load = 1'b0; abort = 1'b0;
      end
    end
    pop = $countones(ev);
    commit_exp = (kind == 0) && (pop != 0);
    check(bc == (commit_exp ? W : 0), commit_exp ? "R6" : req, "busy cycles", bc,
          commit_exp ? W : 0);
    check(nw == (commit_exp ? pop : 0), commit_exp ? "R4" : req, "write count", nw,
          commit_exp ? pop : 0);
    for (int k = 0; k < nw; k++) begin
      check(wa[k][16:7] == row, "R2", "write row", int'(wa[k][16:7]), int'(row));
      check(ev[wa[k][6:0]] == 1'b1, "R4", "column marked", int'(wa[k][6:0]), 1);
      check(wd[k] == ed[wa[k][6:0]], req, "write data", int'(wd[k]),
            int'(ed[wa[k][6:0]]));
      check(wb[k] == k + 1, "R5", "write slot", wb[k], k + 1);
      if (k > 0)
        check(wa[k][6:0] > wa[k-1][6:0], "R5", "column order", int'(wa[k][6:0]),
              int'(wa[k-1][6:0]) + 1);
    end
  endtask

  task automatic lone_stop();
    int bc;
    bc = 0;
    @(posedge clk); #1 stop_ok = 1'b1;
    @(posedge clk); #1 stop_ok = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (busy || mem_we) bc++;
    end
    check(bc == 0, "R9", "cycle after lone stop", bc, 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(mem_we == 1'b0, "R1", "we in reset", mem_we, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && mem_we == 1'b0, "R1", "idle after reset",
          int'({busy, mem_we}), 0);

    for (int i = 0; i < 6; i++) begin
      logic [34:0] v;
      v = VEC[i];
      run_cmd(v[34:25], v[24:18], int'(v[17:10]), v[9:2], int'(v[1:0]), 0, 1'b0,
              (v[1:0] != 2'd0) ? "R7" : ((i == 2 || i == 3) ? "R3" : "R2"));
    end

    run_cmd(10'd40, 7'd126, 9, 8'h5A, 0, 2, 1'b0, "R8");   // alternate inhibited bytes
    run_cmd(10'd41, 7'd0,   6, 8'h66, 0, 1, 1'b0, "R8");   // all inhibited
    lone_stop();                                           // R9 after empty command
    run_cmd(10'd77, 7'd30,  5, 8'h90, 0, 0, 1'b1, "R9");   // inputs during busy
    lone_stop();                                           // R9 map cleared

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule